// File: doc/BRIEF.md
# Two-Wire Serial Bus Condition Monitor

This block observes a shared two-wire serial bus (a clock line and a data line) from a synchronous system clock. Each raw line first passes through a two-flop synchronizer and then through a digital glitch filter. The filter accepts a new level only after the level has held steady for a set number of system clock cycles. The filtered levels are decoded into bus conditions: start, repeated start and stop. Each condition is reported as a pulse that lasts one system clock cycle.

A busy flag follows the ownership of the bus. A start sets it at once. A stop begins a free-time countdown, and the flag stays set until the countdown finishes. The countdown length depends on the speed selected by a mode input: one count for 100 kHz timing and a shorter count for 400 kHz timing. A start that arrives during the countdown cancels it. The monitor also produces a strobe on every rising edge of the filtered clock line, together with the filtered data level at that edge. A byte engine placed after this block can shift in data from that strobe.

The filter length and both free-time counts are parameters counted in system clock cycles. Their defaults come from the clock frequency parameter: 100 ns for the filter, 4.7 µs for standard mode and 1.3 µs for fast mode.

Top module: `i2c_cond_monitor`

## Requirements
- R1: A synchronous active-high reset sets both filtered levels high and clears the busy flag. It also holds startPulse, rstartPulse, stopPulse and bitStrobe low.
- R2: A line level that lasts fewer than FILT_CYCLES system clock cycles never reaches the filtered outputs and decodes to no event. A level held for FILT_CYCLES cycles does reach the filtered outputs.
- R3: The block raises startPulse when the filtered data line falls while the filtered clock line is high and the bus is free or counting free time. busBusy is high in the same cycle as that pulse.
- R4: A start condition while busBusy is high and no free-time countdown runs raises rstartPulse and not startPulse, and busBusy stays high.
- R5: The block raises stopPulse when the filtered data line rises while the filtered clock line is high. A stop on a busy bus leaves busBusy high during the pulse.
- R6: After a stop on a busy bus, busBusy falls exactly FREE_STD_CYCLES cycles after stopPulse rises when fastMode is 0. It falls exactly FREE_FAST_CYCLES cycles after stopPulse rises when fastMode is 1.
- R7: A start during the free-time countdown raises startPulse and cancels the countdown, and busBusy never goes low.
- R8: bitStrobe pulses once for each rising edge of the filtered clock line, and bitValue carries the filtered data level at that edge.
- R9: Each event output is high for exactly one cycle, and at most one of startPulse, rstartPulse and stopPulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line |
| fastMode | input | 1 | 0 selects standard free time, 1 selects fast free time |
| sclFilt | output | 1 | Filtered clock line level |
| sdaFilt | output | 1 | Filtered data line level |
| startPulse | output | 1 | Start condition on a bus that is not busy |
| rstartPulse | output | 1 | Repeated start on a busy bus |
| stopPulse | output | 1 | Stop condition |
| bitStrobe | output | 1 | Rising edge of the filtered clock line |
| bitValue | output | 1 | Filtered data level at the bitStrobe edge |
| busBusy | output | 1 | Bus busy flag |

## Verification
The bench builds the monitor with FILT_CYCLES = 5, FREE_STD_CYCLES = 100 and FREE_FAST_CYCLES = 60. With a filter that short, the bench can drive a glitch one cycle below the limit and a pulse of exactly the limit in a few cycles, so both sides of the rejection boundary get exercised. With the two free counts far apart, a stop measured in each mode shows which count was applied, to the exact cycle. A start cannot cut into a countdown unless it arrives before the countdown ends. Because the standard count is long, a start can be placed inside it after the bus lines have settled.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // Edge and level facts derived from the filtered lines
  typedef struct packed {
    logic sdaFall;
    logic sdaRise;
    logic sclRise;
    logic sclHigh;
  } lineEvents_t;

  // Strobes from control into the datapath free-time counter
  typedef struct packed {
    logic loadFree;
    logic cancelFree;
    logic modeFast;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    BUS_FREE = 2'd0,
    BUS_BUSY = 2'd1,
    BUS_HOLD = 2'd2
  } busState_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic level
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic syncA, syncB;
  logic [CW-1:0] holdCnt;

  // two-flop synchronizer, idle-high
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  // accept a new level only after FILT_CYCLES steady cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b1;
      holdCnt <= '0;
    end else if (syncB == level) begin
      holdCnt <= '0;
    end else if (holdCnt == LAST) begin
      level   <= syncB;
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int FILT_CYCLES      = 10,
  parameter int FREE_STD_CYCLES  = 470,
  parameter int FREE_FAST_CYCLES = 130
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  ctrlStrobes_t strobes,
  output logic         sclLevel,
  output logic         sdaLevel,
  output lineEvents_t  events,
  output logic         freeDone
);
  localparam int NLINES  = 2;
  localparam int FREE_MAX = (FREE_STD_CYCLES > FREE_FAST_CYCLES) ? FREE_STD_CYCLES : FREE_FAST_CYCLES;
  localparam int FW = $clog2(FREE_MAX + 1);
  localparam logic [FW-1:0] STD_LOAD  = FW'(FREE_STD_CYCLES - 1);
  localparam logic [FW-1:0] FAST_LOAD = FW'(FREE_FAST_CYCLES - 1);

  logic [NLINES-1:0] rawLines;
  logic [NLINES-1:0] filtLines;
  logic prevScl, prevSda;
  logic [FW-1:0] freeCnt;

  assign rawLines = {sclIn, sdaIn};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2c_line_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
      .clk  (clk),
      .rst  (rst),
      .rawIn(rawLines[i]),
      .level(filtLines[i])
    );
  end

  assign sclLevel = filtLines[1];
  assign sdaLevel = filtLines[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclLevel;
      prevSda <= sdaLevel;
    end
  end

  always_comb begin
    events.sclHigh = sclLevel & prevScl;
    events.sclRise = sclLevel & ~prevScl;
    events.sdaFall = prevSda & ~sdaLevel;
    events.sdaRise = ~prevSda & sdaLevel;
  end

  // free-time countdown
  always_ff @(posedge clk) begin
    if (rst) begin
      freeCnt <= '0;
    end else if (strobes.loadFree) begin
      freeCnt <= strobes.modeFast ? FAST_LOAD : STD_LOAD;
    end else if (strobes.cancelFree) begin
      freeCnt <= '0;
    end else if (freeCnt != '0) begin
      freeCnt <= freeCnt - 1'b1;
    end
  end

  assign freeDone = (freeCnt == '0);
endmodule

// File: rtl/i2c_mon_control.sv
module i2c_mon_control
  import i2c_mon_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fastMode,
  input  lineEvents_t  events,
  input  logic         sdaLevel,
  input  logic         freeDone,
  output ctrlStrobes_t strobes,
  output logic         startPulse,
  output logic         rstartPulse,
  output logic         stopPulse,
  output logic         bitStrobe,
  output logic         bitValue,
  output logic         busBusy
);
  busState_t state, stateNxt;
  logic isStart, isStop;
  logic startD, rstartD, stopD;

  assign isStart = events.sclHigh & events.sdaFall;
  assign isStop  = events.sclHigh & events.sdaRise;

  always_comb begin
    stateNxt           = state;
    strobes.loadFree   = 1'b0;
    strobes.cancelFree = 1'b0;
    strobes.modeFast   = fastMode;
    startD             = 1'b0;
    rstartD            = 1'b0;
    stopD              = 1'b0;
    unique case (state)
      BUS_FREE: begin
        if (isStart) begin
          startD   = 1'b1;
          stateNxt = BUS_BUSY;
        end else if (isStop) begin
          stopD = 1'b1;
        end
      end
      BUS_BUSY: begin
        if (isStart) begin
          rstartD = 1'b1;
        end else if (isStop) begin
          stopD            = 1'b1;
          strobes.loadFree = 1'b1;
          stateNxt         = BUS_HOLD;
        end
      end
      BUS_HOLD: begin
        if (isStart) begin
          startD             = 1'b1;
          strobes.cancelFree = 1'b1;
          stateNxt           = BUS_BUSY;
        end else if (isStop) begin
          stopD            = 1'b1;
          strobes.loadFree = 1'b1;
        end else if (freeDone) begin
          stateNxt = BUS_FREE;
        end
      end
      default: stateNxt = BUS_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= BUS_FREE;
      startPulse  <= 1'b0;
      rstartPulse <= 1'b0;
      stopPulse   <= 1'b0;
      bitStrobe   <= 1'b0;
      bitValue    <= 1'b0;
    end else begin
      state       <= stateNxt;
      startPulse  <= startD;
      rstartPulse <= rstartD;
      stopPulse   <= stopD;
      bitStrobe   <= events.sclRise;
      if (events.sclRise) bitValue <= sdaLevel;
    end
  end

  assign busBusy = (state != BUS_FREE);
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_mon_pkg::*;
#(
  parameter int CLK_HZ           = 100_000_000,
  parameter int FILT_CYCLES      = (CLK_HZ + 9_999_999) / 10_000_000,
  parameter int FREE_STD_CYCLES  = ((CLK_HZ / 1000) * 47 + 9999) / 10000,
  parameter int FREE_FAST_CYCLES = ((CLK_HZ / 1000) * 13 + 9999) / 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic fastMode,
  output logic sclFilt,
  output logic sdaFilt,
  output logic startPulse,
  output logic rstartPulse,
  output logic stopPulse,
  output logic bitStrobe,
  output logic bitValue,
  output logic busBusy
);
  lineEvents_t  events;
  ctrlStrobes_t strobes;
  logic         freeDone;

  i2c_mon_datapath #(
    .FILT_CYCLES     (FILT_CYCLES),
    .FREE_STD_CYCLES (FREE_STD_CYCLES),
    .FREE_FAST_CYCLES(FREE_FAST_CYCLES)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strobes (strobes),
    .sclLevel(sclFilt),
    .sdaLevel(sdaFilt),
    .events  (events),
    .freeDone(freeDone)
  );

  i2c_mon_control ctl_i (
    .clk        (clk),
    .rst        (rst),
    .fastMode   (fastMode),
    .events     (events),
    .sdaLevel   (sdaFilt),
    .freeDone   (freeDone),
    .strobes    (strobes),
    .startPulse (startPulse),
    .rstartPulse(rstartPulse),
    .stopPulse  (stopPulse),
    .bitStrobe  (bitStrobe),
    .bitValue   (bitValue),
    .busBusy    (busBusy)
  );
endmodule

// File: rtl/i2c_cond_monitor_chk.sv
module i2c_cond_monitor_chk #(
  parameter int FREE_STD_CYCLES  = 470,
  parameter int FREE_FAST_CYCLES = 130
) (
  input logic clk,
  input logic rst,
  input logic fastMode,
  input logic sclFilt,
  input logic sdaFilt,
  input logic startPulse,
  input logic rstartPulse,
  input logic stopPulse,
  input logic bitStrobe,
  input logic busBusy
);
  int holdCnt;
  int holdExp;

  // window counter: cycles since a stop on a busy bus
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= 0;
      holdExp <= 0;
    end else if (stopPulse && busBusy) begin
      holdCnt <= 1;
      holdExp <= $past(fastMode) ? FREE_FAST_CYCLES : FREE_STD_CYCLES;
    end else if (startPulse) begin
      holdCnt <= 0;
    end else if (holdCnt != 0) begin
      holdCnt <= holdCnt + 1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (sclFilt && sdaFilt && !busBusy && !startPulse && !rstartPulse && !stopPulse && !bitStrobe)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> busBusy); // R3
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busBusy) |-> startPulse); // R3
  AST_RSTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    rstartPulse |-> (busBusy && $past(busBusy))); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stopPulse && $past(busBusy)) |-> busBusy); // R5
  AST_FREE_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(busBusy) |-> (holdCnt == holdExp)); // R6
  AST_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |-> (sclFilt && $past(sclFilt) && !$past(sclFilt, 2))); // R8
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startPulse, rstartPulse, stopPulse})); // R9
  AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse); // R9
  AST_STOP_ONE: assert property (@(posedge clk) disable iff (rst)
    stopPulse |=> !stopPulse); // R9
  AST_BIT_ONE: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |=> !bitStrobe); // R9
endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk #(
  .FREE_STD_CYCLES (FREE_STD_CYCLES),
  .FREE_FAST_CYCLES(FREE_FAST_CYCLES)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .fastMode   (fastMode),
  .sclFilt    (sclFilt),
  .sdaFilt    (sdaFilt),
  .startPulse (startPulse),
  .rstartPulse(rstartPulse),
  .stopPulse  (stopPulse),
  .bitStrobe  (bitStrobe),
  .busBusy    (busBusy)
);

// File: tb/i2c_cond_monitor_tb_top.sv
module i2c_cond_monitor_tb_top;
  localparam int FILT  = 5;
  localparam int FSTD  = 100;
  localparam int FFAST = 60;
  localparam int HOLD  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclIn = 1'b1, sdaIn = 1'b1, fastMode = 1'b0;
  logic sclFilt, sdaFilt, startPulse, rstartPulse, stopPulse, bitStrobe, bitValue, busBusy;

  int checks = 0;
  int errors = 0;

  typedef struct { byte kind; bit val; } expItem_t;
  expItem_t expQ[$];

  bit benchBusy = 0;   // bus owned and not counting free time
  int expFree   = FSTD;
  bit watchSda  = 0, watchScl = 0;
  int sdaLowSeen = 0, sclLowSeen = 0;
  bit busyLowSeen = 0;
  bit watchBusy = 0;

  always #5 clk = ~clk;

  i2c_cond_monitor #(
    .FILT_CYCLES(FILT), .FREE_STD_CYCLES(FSTD), .FREE_FAST_CYCLES(FFAST)
  ) dut_i (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .fastMode(fastMode),
    .sclFilt(sclFilt), .sdaFilt(sdaFilt), .startPulse(startPulse),
    .rstartPulse(rstartPulse), .stopPulse(stopPulse), .bitStrobe(bitStrobe),
    .bitValue(bitValue), .busBusy(busBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // ---------------- driver ----------------
  task automatic push(input byte k, input bit v);
    expItem_t it;
    it.kind = k;
    it.val  = v;
    expQ.push_back(it);
  endtask

  task automatic startCond();
    sdaIn = 1'b1; waitc(HOLD);
    sclIn = 1'b1;
    if (!sclFilt) push("B", 1'b1);
    waitc(HOLD);
    push(benchBusy ? "R" : "S", 1'b0);
    benchBusy = 1;
    sdaIn = 1'b0; waitc(HOLD);
    sclIn = 1'b0; waitc(HOLD);
  endtask

  task automatic sendBit(input bit b);
    sdaIn = b; waitc(HOLD);
    push("B", b);
    sclIn = 1'b1; waitc(HOLD);
    sclIn = 1'b0; waitc(HOLD);
  endtask

  task automatic stopCond();
    sdaIn = 1'b0; waitc(HOLD);
    push("B", 1'b0);
    sclIn = 1'b1; waitc(HOLD);
    push("P", 1'b0);
    expFree = fastMode ? FFAST : FSTD;
    benchBusy = 0;
    sdaIn = 1'b1; waitc(HOLD);
  endtask

  // ---------------- monitor ----------------
  bit prevStart = 0, prevRstart = 0, prevStop = 0, prevBit = 0;
  bit waitFree = 0;
  int freeCnt = 0;

  task automatic popCheck(input byte k, input bit v);
    expItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, "R3/R4/R5/R8 unexpected event", int'(k), 0);
    end else begin
      it = expQ.pop_front();
      check(it.kind == k, "R3/R4/R5/R8 event kind", int'(k), int'(it.kind));
      if (k == "B") check(it.val == v, "R8 bitValue", int'(v), int'(it.val));
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (startPulse)  popCheck("S", 1'b0);
      if (rstartPulse) popCheck("R", 1'b0);
      if (stopPulse)   popCheck("P", 1'b0);
      if (bitStrobe)   popCheck("B", bitValue);
      if (startPulse) check(busBusy, "R3 busy with start", int'(busBusy), 1);
      if (rstartPulse || (stopPulse && waitFree == 0 && prevStop == 0 && busBusy == 0 && 0))
        check(busBusy, "R4 busy kept", int'(busBusy), 1);
      if ((startPulse && prevStart) || (rstartPulse && prevRstart) ||
          (stopPulse && prevStop) || (bitStrobe && prevBit))
        check(1'b0, "R9 pulse wider than one cycle", 2, 1);
      if ((int'(startPulse) + int'(rstartPulse) + int'(stopPulse)) > 1)
        check(1'b0, "R9 overlapping events", 2, 1);
      prevStart  = startPulse;
      prevRstart = rstartPulse;
      prevStop   = stopPulse;
      prevBit    = bitStrobe;
      if (watchSda && !sdaFilt) sdaLowSeen++;
      if (watchScl && !sclFilt) sclLowSeen++;
      if (watchBusy && !busBusy) busyLowSeen = 1;
      if (stopPulse) begin
        check(busBusy, "R5 busy during stop", int'(busBusy), 1);
        waitFree = 1;
        freeCnt  = 0;
      end else if (waitFree) begin
        freeCnt++;
        if (startPulse) begin
          waitFree = 0;
        end else if (!busBusy) begin
          check(freeCnt == expFree, "R6 free time", freeCnt, expFree);
          waitFree = 0;
        end
      end
    end
  end

  // ---------------- sequence ----------------
  initial begin
    waitc(3);
    #4;
    check(!busBusy && sclFilt && sdaFilt && !startPulse && !rstartPulse && !stopPulse && !bitStrobe,
          "R1 reset state", int'({busBusy, sclFilt, sdaFilt}), 3'b011);
    @(posedge clk); #1;
    rst = 1'b0;
    waitc(HOLD);

    // R2: data glitch one cycle short of the filter on an idle bus
    watchSda = 1; sdaLowSeen = 0;
    sdaIn = 1'b0; waitc(FILT - 1);
    sdaIn = 1'b1; waitc(HOLD);
    watchSda = 0;
    check(sdaLowSeen == 0, "R2 short sda glitch rejected", sdaLowSeen, 0);

    // R2: clock glitch one cycle short
    watchScl = 1; sclLowSeen = 0;
    sclIn = 1'b0; waitc(FILT - 1);
    sclIn = 1'b1; waitc(HOLD);
    watchScl = 0;
    check(sclLowSeen == 0, "R2 short scl glitch rejected", sclLowSeen, 0);

    // R2 boundary: sda low for exactly FILT cycles passes -> start then stop
    push("S", 1'b0);
    watchSda = 1; sdaLowSeen = 0;
    sdaIn = 1'b0; waitc(FILT);
    push("P", 1'b0);
    expFree = FSTD;
    sdaIn = 1'b1; waitc(HOLD);
    watchSda = 0;
    check(sdaLowSeen > 0, "R2 full-length pulse accepted", sdaLowSeen, 1);
    waitc(FSTD + HOLD);
    check(!busBusy, "R6 free after standard wait", int'(busBusy), 0);

    // R3 R8 R4 R5 R6: transfer in standard mode with a repeated start
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    startCond();
    sendBit(1'b0); sendBit(1'b1);
    stopCond();
    waitc(FSTD + HOLD);
    check(!busBusy, "R6 bus free after stop", int'(busBusy), 0);

    // R6 fast mode
    fastMode = 1'b1;
    startCond();
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    stopCond();
    waitc(FFAST + HOLD);
    check(!busBusy, "R6 fast free after stop", int'(busBusy), 0);

    // R7: start during countdown (standard mode)
    fastMode = 1'b0;
    startCond();
    sendBit(1'b1);
    stopCond();
    watchBusy = 1; busyLowSeen = 0;
    startCond();
    watchBusy = 0;
    check(!busyLowSeen, "R7 busy never dropped", int'(busyLowSeen), 0);
    check(busBusy, "R7 busy after start in countdown", int'(busBusy), 1);
    sendBit(1'b0);
    stopCond();
    waitc(FSTD + HOLD);

    check(expQ.size() == 0, "R3/R8 all expected events seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule